// File: doc/BRIEF.md
# Edge/Level Interrupt Capture and Vector Router

This block is the capture and delivery core of a 64-source I/O interrupt controller. Each raw input line is sampled every clock as either edge-triggered or level-triggered. The per-source state is a request bit, an in-service bit and the level seen on the previous cycle. A requested source is delivered when it is unmasked and not already in service. Delivery sets its in-service bit and raises one of 64 parent lines, which a per-source vector entry selects.

Software-side configuration reaches the block through plain write ports: a mask word, a trigger-mode word and an indexed vector byte. A clear strobe with a bit mask retires serviced interrupts. Mask and mode writes take effect in the same cycle they are presented, so every input change or write shows on the parent lines exactly one clock later. Inputs must be synchronous to `clk`.

Top module: `irq_route_core`

## Requirements
- R1: After reset every source is masked, every source is in level mode, every vector entry is 0 and all parent lines are low. Raising inputs before any mask write delivers nothing. Unmasking in level mode then routes all active sources to parent line 0.
- R2: A source whose mode bit is 1 (edge) captures a request when its input is 1 and was 0 on the previous cycle. The request, and a delivery made from it, persists after the input falls, until a clear removes it.
- R3: A source whose mode bit is 0 (level) has a request that equals its input. Its parent line rises one cycle after the input rises and falls one cycle after the input falls.
- R4: A delivered source drives the parent line numbered by bits [5:0] of its vector byte. Bits [7:6] are ignored, and index 63 reaches line 63.
- R5: Each parent line is the OR of all in-service sources routed to it. Retiring one source leaves the line high while another source on it is still in service.
- R6: A clear strobe clears the in-service bit of every source whose `clr_bits` bit is 1. For edge sources it also removes the request. A level source whose input is still high is delivered again one cycle after the strobe.
- R7: A clear strobe has no effect on sources whose `clr_bits` bit is 0.
- R8: A mask bit of 1 withdraws delivery and clears in-service but keeps the request. Clearing the mask bit delivers a pending request on the next cycle.
- R9: When a clear and a new rising edge reach the same edge source in one cycle, the clear takes the in-service bit for that cycle and the new request is kept. The source is delivered again one cycle later.
- R10: An edge source whose input stays high after a clear raises no new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 64 | Raw interrupt lines, one per source |
| mask_we | input | 1 | Write enable for the mask word |
| mask_val | input | 64 | New mask word, 1 blocks a source |
| edge_we | input | 1 | Write enable for the trigger-mode word |
| edge_val | input | 64 | New trigger-mode word, 1 edge, 0 level |
| vec_we | input | 1 | Write enable for one vector byte |
| vec_idx | input | 6 | Source whose vector byte is written |
| vec_val | input | 8 | Vector byte, bits [5:0] select the parent line |
| clr_strobe | input | 1 | One-cycle clear command |
| clr_bits | input | 64 | Sources affected by the clear |
| parent_out | output | 64 | Parent interrupt lines |

## Verification
The case that needs the most care is a clear strobe and a fresh rising edge on the same edge source in the same cycle. Retiring and capturing then compete for that one source's state. The bench first lets the input fall, then raises it in the same cycle it pulses the clear for that source. It expects the parent line low in the following cycle and high again the cycle after that, because the new request must survive. A second overlap, a clear on a level source whose input is still high, is judged the same way: one low cycle, then redelivery.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned DEF_NUM_SRC = 64;
  localparam int unsigned DEF_NUM_OUT = 64;
  localparam int unsigned DEF_VEC_W   = 8;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned NUM_SRC = irq_route_pkg::DEF_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_val,
  input  logic               edge_we,
  input  logic [NUM_SRC-1:0] edge_val,
  output logic [NUM_SRC-1:0] mask_eff,
  output logic [NUM_SRC-1:0] edge_eff
);
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic [NUM_SRC-1:0] edge_q, edge_d;

  // write-through: a value presented this cycle already governs capture
  always_comb begin
    mask_d   = mask_we ? mask_val : mask_q;
    edge_d   = edge_we ? edge_val : edge_q;
    mask_eff = mask_d;
    edge_eff = edge_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      edge_q <= '0;
    end else begin
      if (mask_we) mask_q <= mask_d;
      if (edge_we) edge_q <= edge_d;
    end
  end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int unsigned NUM_SRC = irq_route_pkg::DEF_NUM_SRC,
  parameter int unsigned NUM_OUT = irq_route_pkg::DEF_NUM_OUT,
  parameter int unsigned VEC_W   = irq_route_pkg::DEF_VEC_W,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned SEL_W  = $clog2(NUM_OUT)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           vec_we,
  input  logic [IDX_W-1:0]               vec_idx,
  input  logic [VEC_W-1:0]               vec_val,
  output logic [NUM_SRC-1:0][SEL_W-1:0]  sel
);
  logic [NUM_SRC-1:0][SEL_W-1:0] sel_q;
  logic [NUM_SRC-1:0]            row_we;

  generate
    if (VEC_W > SEL_W) begin : g_hi
      logic unused_vec_hi;
      assign unused_vec_hi = ^vec_val[VEC_W-1:SEL_W];
    end
  endgenerate

  always_comb begin
    row_we = '0;
    if (vec_we) row_we[vec_idx] = 1'b1;
  end

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sel_q[s] <= '0;
        else if (row_we[s]) sel_q[s] <= vec_val[SEL_W-1:0];
      end
    end
  endgenerate

  assign sel = sel_q;
endmodule

// File: rtl/irq_capture.sv
module irq_capture
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] edge_eff,
  input  logic [NUM_SRC-1:0] mask_eff,
  input  logic [NUM_SRC-1:0] clr_v,
  output logic [NUM_SRC-1:0] req_q,
  output logic [NUM_SRC-1:0] isr_q
);
  logic [NUM_SRC-1:0] lvl_q;
  logic [NUM_SRC-1:0] req_d, isr_d;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      logic rise, kill;
      rise = irq_in[i] & ~lvl_q[i];
      if (edge_eff[i] == TRIG_EDGE) begin
        // old request retired first, a new edge in the same cycle survives
        req_d[i] = (req_q[i] & ~clr_v[i]) | rise;
        kill     = clr_v[i] | mask_eff[i];
      end else begin
        req_d[i] = irq_in[i];
        kill     = clr_v[i] | mask_eff[i] | ~irq_in[i];
      end
      isr_d[i] = ~kill & (isr_q[i] | req_d[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      req_q <= '0;
      isr_q <= '0;
    end else begin
      lvl_q <= irq_in;
      req_q <= req_d;
      isr_q <= isr_d;
    end
  end
endmodule

// File: rtl/irq_out_router.sv
module irq_out_router #(
  parameter int unsigned NUM_SRC = irq_route_pkg::DEF_NUM_SRC,
  parameter int unsigned NUM_OUT = irq_route_pkg::DEF_NUM_OUT,
  localparam int unsigned SEL_W  = $clog2(NUM_OUT)
) (
  input  logic [NUM_SRC-1:0]            isr_q,
  input  logic [NUM_SRC-1:0][SEL_W-1:0] sel,
  output logic [NUM_OUT-1:0]            parent_out
);
  always_comb begin
    parent_out = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (isr_q[i]) parent_out[sel[i]] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_route_core.sv
module irq_route_core #(
  parameter int unsigned NUM_SRC = irq_route_pkg::DEF_NUM_SRC,
  parameter int unsigned NUM_OUT = irq_route_pkg::DEF_NUM_OUT,
  parameter int unsigned VEC_W   = irq_route_pkg::DEF_VEC_W,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned SEL_W  = $clog2(NUM_OUT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_val,
  input  logic               edge_we,
  input  logic [NUM_SRC-1:0] edge_val,
  input  logic               vec_we,
  input  logic [IDX_W-1:0]   vec_idx,
  input  logic [VEC_W-1:0]   vec_val,
  input  logic               clr_strobe,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_OUT-1:0] parent_out
);
  logic [1:0]                    rst_pipe_q;
  logic                          rst_sync_n;
  logic [NUM_SRC-1:0]            mask_eff, edge_eff, clr_v;
  logic [NUM_SRC-1:0]            req_q, isr_q;
  logic [NUM_SRC-1:0][SEL_W-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign clr_v = clr_strobe ? clr_bits : '0;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n),
    .mask_we(mask_we), .mask_val(mask_val),
    .edge_we(edge_we), .edge_val(edge_val),
    .mask_eff(mask_eff), .edge_eff(edge_eff)
  );

  irq_vec_table #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .VEC_W(VEC_W)) u_vec (
    .clk(clk), .rst_n(rst_sync_n),
    .vec_we(vec_we), .vec_idx(vec_idx), .vec_val(vec_val),
    .sel(sel)
  );

  irq_capture #(.NUM_SRC(NUM_SRC)) u_cap (
    .clk(clk), .rst_n(rst_sync_n),
    .irq_in(irq_in), .edge_eff(edge_eff), .mask_eff(mask_eff), .clr_v(clr_v),
    .req_q(req_q), .isr_q(isr_q)
  );

  irq_out_router #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_rte (
    .isr_q(isr_q), .sel(sel), .parent_out(parent_out)
  );
endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker #(
  parameter int unsigned NUM_SRC = irq_route_pkg::DEF_NUM_SRC,
  parameter int unsigned NUM_OUT = irq_route_pkg::DEF_NUM_OUT
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_in,
  input logic               clr_strobe,
  input logic [NUM_SRC-1:0] clr_bits,
  input logic [NUM_SRC-1:0] edge_eff,
  input logic [NUM_SRC-1:0] mask_eff,
  input logic [NUM_SRC-1:0] req_q,
  input logic [NUM_SRC-1:0] isr_q,
  input logic [NUM_OUT-1:0] parent_out
);
  logic [NUM_SRC-1:0] chk_clr;
  assign chk_clr = clr_strobe ? clr_bits : '0;

  assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(edge_eff) & (req_q ^ $past(irq_in))) == '0));

  assert_edge_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_eff & req_q & ~chk_clr) & ~req_q) == '0));

  assert_isr_in_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_q & ~req_q) == '0));

  assert_mask_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((isr_q & $past(mask_eff)) == '0));

  assert_clear_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((isr_q & $past(chk_clr)) == '0));

  assert_idle_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q == '0) |-> (parent_out == '0));
endmodule

bind irq_route_core irq_route_checker #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .irq_in(irq_in),
  .clr_strobe(clr_strobe), .clr_bits(clr_bits),
  .edge_eff(edge_eff), .mask_eff(mask_eff),
  .req_q(req_q), .isr_q(isr_q), .parent_out(parent_out)
);

// File: tb/irq_route_core_tb.sv
module irq_route_core_tb;
  localparam logic [63:0] ALLM = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] UM   = 64'hFFFF_FFFF_FFFF_FFF0;
  localparam logic [63:0] EG   = 64'h0000_0000_0000_0005;

  typedef struct packed {
    logic [63:0] in_v;
    logic [63:0] msk_v;
    logic [63:0] edg_v;
    logic [63:0] clr_v;
    logic        go;
    logic [3:0]  req;
    logic [63:0] exp_v;
  } step_t;

  // src0 edge->line5, src1 level->line5, src2 edge->line9, src3 level byte 0xC7->line7
  localparam int NSTEP = 18;
  localparam step_t TBL [NSTEP] = '{
    '{64'h0, UM, EG, 64'h0, 1'b0, 4'd3,  64'h000},  // R3 idle
    '{64'h1, UM, EG, 64'h0, 1'b0, 4'd2,  64'h020},  // R2 rise
    '{64'h0, UM, EG, 64'h0, 1'b0, 4'd2,  64'h020},  // R2 held after fall
    '{64'h2, UM, EG, 64'h0, 1'b0, 4'd5,  64'h020},  // R5 shared line
    '{64'h2, UM, EG, 64'h1, 1'b1, 4'd5,  64'h020},  // R5 one retired, other holds
    '{64'h0, UM, EG, 64'h0, 1'b0, 4'd3,  64'h000},  // R3 level falls
    '{64'h8, UM, EG, 64'h0, 1'b0, 4'd4,  64'h080},  // R4 upper vector bits ignored
    '{64'hC, UM, EG, 64'h0, 1'b0, 4'd4,  64'h280},  // R4 second line
    '{64'hC, UM, EG, 64'h8, 1'b1, 4'd6,  64'h200},  // R6 level clear drops
    '{64'hC, UM, EG, 64'h0, 1'b0, 4'd6,  64'h280},  // R6 level redelivered
    '{64'hC, UM, EG, 64'h4, 1'b1, 4'd6,  64'h080},  // R6 edge clear
    '{64'hC, UM, EG, 64'h0, 1'b0, 4'd10, 64'h080},  // R10 held high, no new request
    '{64'h1, ALLM, EG, 64'h0, 1'b0, 4'd8, 64'h000}, // R8 masked rise pending
    '{64'h0, ALLM, EG, 64'h0, 1'b0, 4'd8, 64'h000}, // R8 still masked
    '{64'h0, UM, EG, 64'h0, 1'b0, 4'd8,  64'h020},  // R8 unmask delivers
    '{64'h0, ALLM, EG, 64'h0, 1'b0, 4'd8, 64'h000}, // R8 mask withdraws
    '{64'h0, UM, EG, 64'h0, 1'b0, 4'd8,  64'h020},  // R8 request kept
    '{64'h0, UM, EG, 64'h1, 1'b1, 4'd6,  64'h000}   // R6 edge retired
  };

  logic        clk;
  logic        rst_n;
  logic [63:0] irq_in, mask_val, edge_val, clr_bits;
  logic        mask_we, edge_we, vec_we, clr_strobe;
  logic [5:0]  vec_idx;
  logic [7:0]  vec_val;
  logic [63:0] parent_out;
  int          n_chk, n_err;

  irq_route_core u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .mask_we(mask_we), .mask_val(mask_val),
    .edge_we(edge_we), .edge_val(edge_val),
    .vec_we(vec_we), .vec_idx(vec_idx), .vec_val(vec_val),
    .clr_strobe(clr_strobe), .clr_bits(clr_bits),
    .parent_out(parent_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic [63:0] exp_v, input int req, input string what);
    n_chk++;
    if (parent_out !== exp_v) begin
      n_err++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, parent_out, exp_v);
    end
  endtask

  task automatic idle_inputs();
    mask_we = 1'b0; edge_we = 1'b0; vec_we = 1'b0; clr_strobe = 1'b0;
    mask_val = '0; edge_val = '0; clr_bits = '0; vec_idx = '0; vec_val = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    irq_in = '0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic step(input logic [63:0] in_v, input logic [63:0] msk_v,
                      input logic [63:0] edg_v, input logic [63:0] cb,
                      input logic go, input logic [63:0] exp_v,
                      input int req, input string what);
    irq_in = in_v;
    mask_we = 1'b1; mask_val = msk_v;
    edge_we = 1'b1; edge_val = edg_v;
    clr_strobe = go; clr_bits = cb;
    @(posedge clk);
    @(negedge clk);
    check(exp_v, req, what);
  endtask

  task automatic write_vec(input logic [5:0] idx, input logic [7:0] val);
    idle_inputs();
    vec_we = 1'b1; vec_idx = idx; vec_val = val;
    @(posedge clk);
    @(negedge clk);
    vec_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    do_reset();
    check(64'h0, 1, "reset outputs low");                        // R1
    irq_in = ALLM;
    @(posedge clk); @(negedge clk);
    check(64'h0, 1, "all masked after reset");                   // R1
    step(ALLM, 64'h0, 64'h0, 64'h0, 1'b0, 64'h1, 1, "level default, vectors 0"); // R1

    do_reset();
    write_vec(6'd0, 8'd5);
    write_vec(6'd1, 8'd5);
    write_vec(6'd2, 8'd9);
    write_vec(6'd3, 8'hC7);
    for (int k = 0; k < NSTEP; k++) begin
      step(TBL[k].in_v, TBL[k].msk_v, TBL[k].edg_v, TBL[k].clr_v, TBL[k].go,
           TBL[k].exp_v, int'(TBL[k].req), $sformatf("table step %0d", k));
    end

    // R9: clear and new rising edge on src2 in the same cycle
    step(64'h0, UM, EG, 64'h0, 1'b0, 64'h000, 9, "prepare low");
    step(64'h4, UM, EG, 64'h4, 1'b1, 64'h000, 9, "clear wins this cycle");
    step(64'h4, UM, EG, 64'h0, 1'b0, 64'h200, 9, "new edge kept");
    step(64'h0, UM, EG, 64'h4, 1'b1, 64'h000, 9, "retired");

    // R4 top index, R7 empty clear
    write_vec(6'd63, 8'h3F);
    step(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 1'b0,
         64'h8000_0000_0000_0000, 4, "index 63 to line 63");
    step(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 1'b1,
         64'h8000_0000_0000_0000, 7, "clear with no bits");
    step(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0,
         64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 64'h8000_0000_0000_0000, 7, "clear other bits");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule